// File: doc/BRIEF.md
# Video Scanout Pixel Requester

This block runs entirely on the pixel clock. It drives a fixed 512 x 342 one-bit-per-pixel raster whose frame buffer sits behind a memory arbiter on a separate, unrelated clock. It counts horizontal and vertical position and produces sync and data-enable strobes. It fetches pixel words one at a time over a four-phase request/acknowledge handshake, and it shifts each 16-bit word out as sixteen consecutive pixels.

A single prefetch register sits between the handshake and the shifter. The fetch for word n+1 therefore runs while word n is being shifted out, and a memory round trip shorter than one word time never stalls the picture. A one-cycle frame-start pulse during vertical blanking tells the memory side to rewind its fetch pointer. At that same pulse the block latches which of the two frame buffers is scanned, and it holds that choice for the whole frame. If a word is late, the block outputs dark pixels and sets a sticky flag. The raster timing keeps running in that case.

Top module: `pixword_scanout`

## Requirements
- R1: `de` is high for exactly H_ACTIVE consecutive cycles on each of the first V_ACTIVE lines of a frame, and is low at all other times. A line lasts H_ACTIVE+H_FRONT+H_SYNC+H_BACK cycles. `hsync` is high for H_SYNC cycles per line and `vsync` is high for V_SYNC lines per frame, and neither is ever high together with `de`.
- R2: While `rst` is held, `word_req`, `frame_start`, `de`, `hsync`, `vsync`, `pix`, `underrun` and `scan_buf` are all 0.
- R3: `frame_start` is a single-cycle pulse issued once per frame period. It is asserted in the first cycle of the last blanking line, with `de` low, exactly one line period before the first active pixel of the frame. No request is raised before the first pulse after reset.
- R4: Between two `frame_start` pulses, `word_req` rises exactly H_ACTIVE/16 x V_ACTIVE times (10944 with default parameters).
- R5: `word_req` rises only while `word_ack`, as seen through a two-flop synchroniser, is low. It then stays high until the synchronised `word_ack` has risen, and it falls in the cycle that captures `word_data`.
- R6: Word k of a frame (counting from 0 after `frame_start`) supplies active pixels 16k to 16k+15 of that frame, counted in raster order. Bit 15 comes out first and bit 0 last, and `pix` equals the bit value (1 = black).
- R7: `pix` is 0 in every cycle where `de` is 0.
- R8: If no word is waiting when the shifter needs one, those 16 pixels are 0 and `underrun` goes to 1. `underrun` then stays 1 until reset, and the raster timing and `frame_start` pulses keep their normal schedule.
- R9: `scan_buf` takes the value of `buf_sel` only in the cycle that `frame_start` is asserted, and holds it unchanged otherwise.
- R10: When every handshake round trip is shorter than 16 pixel clocks, the prefetch keeps the stream fed and `underrun` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| buf_sel | input | 1 | Requested frame buffer (0 main, 1 alternate) |
| word_ack | input | 1 | Acknowledge from the memory clock domain (asynchronous) |
| word_data | input | WORD_BITS | Pixel word, stable from acknowledge rise until the next request |
| word_req | output | 1 | Four-phase fetch request for the next pixel word |
| scan_buf | output | 1 | Frame buffer in use for the current frame |
| frame_start | output | 1 | One-cycle pulse; the memory side rewinds its word pointer |
| de | output | 1 | Active-area data enable |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| pix | output | 1 | Serial pixel, 1 = black |
| underrun | output | 1 | Sticky flag: a word arrived too late |

## Verification
Some properties are checked on every cycle: dark pixels outside the active area, the single-cycle frame pulse in blanking, a request that holds until the synchronised acknowledge and starts only while it is low, the sticky underrun flag, the buffer choice that moves only at the pulse, and sync that never overlaps `de`. Other behaviour only shows up in the bench scenarios, where a memory responder with random latency runs on its own clock. These cover the pixel order and word-to-position mapping across frames and buffer switches, the exact request count per frame, the line and frame periods, and the starved case where the responder stops answering and the picture goes dark while timing holds.

// File: rtl/pws_pkg.sv
package pws_pkg;

  // Registered raster strobes, all delayed by the same single stage.
  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
  } raster_t;

endpackage

// File: rtl/pws_raster.sv
module pws_raster #(
  parameter int H_ACTIVE  = 512,
  parameter int H_FRONT   = 14,
  parameter int H_SYNC    = 32,
  parameter int H_BACK    = 146,
  parameter int V_ACTIVE  = 342,
  parameter int V_FRONT   = 3,
  parameter int V_SYNC    = 4,
  parameter int V_BACK    = 21,
  parameter int WORD_BITS = 16
) (
  input  logic             clk,
  input  logic             rst,
  output logic             in_active,
  output logic             word_slot,
  output logic             frame_hit,
  output pws_pkg::raster_t raster_q,
  output logic             frame_start_q
);
  localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
  localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);
  localparam int SLOT_W  = $clog2(WORD_BITS);
  localparam int HS_ON   = H_ACTIVE + H_FRONT;
  localparam int HS_OFF  = HS_ON + H_SYNC;
  localparam int VS_ON   = V_ACTIVE + V_FRONT;
  localparam int VS_OFF  = VS_ON + V_SYNC;

  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          h_last, v_last, hs_now, vs_now;

  always_comb begin
    h_last    = (h_cnt == HW'(H_TOTAL - 1));
    v_last    = (v_cnt == VW'(V_TOTAL - 1));
    in_active = (h_cnt < HW'(H_ACTIVE)) && (v_cnt < VW'(V_ACTIVE));
    word_slot = in_active && (h_cnt[SLOT_W-1:0] == '0);
    frame_hit = v_last && (h_cnt == '0);
    hs_now    = (h_cnt >= HW'(HS_ON)) && (h_cnt < HW'(HS_OFF));
    vs_now    = (v_cnt >= VW'(VS_ON)) && (v_cnt < VW'(VS_OFF));
  end

  // Reset parks the raster at the start of the last blanking line so the
  // first frame pulse comes one line before the first active pixel.
  always_ff @(posedge clk) begin
    if (rst) begin
      h_cnt         <= '0;
      v_cnt         <= VW'(V_TOTAL - 1);
      raster_q      <= '0;
      frame_start_q <= 1'b0;
    end else begin
      h_cnt <= h_last ? '0 : h_cnt + 1'b1;
      if (h_last) v_cnt <= v_last ? '0 : v_cnt + 1'b1;
      raster_q      <= '{de: in_active, hs: hs_now, vs: vs_now};
      frame_start_q <= frame_hit;
    end
  end

endmodule

// File: rtl/pws_sync.sv
module pws_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic rise
);
  // STAGES flops of synchroniser plus one more for edge detection.
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], async_in};
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~chain[STAGES];

endmodule

// File: rtl/pws_fetch.sv
module pws_fetch #(
  parameter int WORD_BITS       = 16,
  parameter int WORDS_PER_FRAME = 10944
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_start,
  input  logic                 ack_level,
  input  logic                 ack_rise,
  input  logic                 take,
  input  logic [WORD_BITS-1:0] word_in,
  output logic                 req,
  output logic                 pf_valid,
  output logic [WORD_BITS-1:0] pf_data
);
  localparam int CW = $clog2(WORDS_PER_FRAME + 1);

  logic [CW-1:0] left;
  logic          launch, land;

  // Start a handshake only when the previous one has fully returned to
  // idle, the prefetch slot is free and the frame still owes words.
  always_comb begin
    launch = !req && !ack_level && !pf_valid && (left != '0) && !frame_start;
    land   = req && ack_rise;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req      <= 1'b0;
      pf_valid <= 1'b0;
      pf_data  <= '0;
      left     <= '0;
    end else begin
      if (frame_start) left <= CW'(WORDS_PER_FRAME);
      else if (launch) left <= left - 1'b1;

      if (launch)    req <= 1'b1;
      else if (land) req <= 1'b0;

      if (land) pf_data <= word_in;

      if (frame_start) pf_valid <= 1'b0;
      else if (land)   pf_valid <= 1'b1;
      else if (take)   pf_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/pws_shifter.sv
module pws_shifter #(
  parameter int WORD_BITS = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 take,
  input  logic                 in_active,
  input  logic                 pf_valid,
  input  logic [WORD_BITS-1:0] pf_data,
  output logic                 pix,
  output logic                 underrun
);
  localparam int MSB = WORD_BITS - 1;

  logic [MSB:0] sh, fresh;

  assign fresh = pf_valid ? pf_data : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      pix      <= 1'b0;
      underrun <= 1'b0;
    end else if (take) begin
      pix <= fresh[MSB];
      sh  <= {fresh[MSB-1:0], 1'b0};
      if (!pf_valid) underrun <= 1'b1;
    end else begin
      pix <= in_active & sh[MSB];
      sh  <= {sh[MSB-1:0], 1'b0};
    end
  end

endmodule

// File: rtl/pixword_scanout.sv
module pixword_scanout #(
  parameter int H_ACTIVE    = 512,
  parameter int H_FRONT     = 14,
  parameter int H_SYNC      = 32,
  parameter int H_BACK      = 146,
  parameter int V_ACTIVE    = 342,
  parameter int V_FRONT     = 3,
  parameter int V_SYNC      = 4,
  parameter int V_BACK      = 21,
  parameter int WORD_BITS   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 buf_sel,
  input  logic                 word_ack,
  input  logic [WORD_BITS-1:0] word_data,
  output logic                 word_req,
  output logic                 scan_buf,
  output logic                 frame_start,
  output logic                 de,
  output logic                 hsync,
  output logic                 vsync,
  output logic                 pix,
  output logic                 underrun
);
  localparam int WORDS_PER_FRAME = (H_ACTIVE / WORD_BITS) * V_ACTIVE;

  logic                 in_active, word_slot, frame_hit;
  logic                 ack_level, ack_rise;
  logic                 pf_valid;
  logic [WORD_BITS-1:0] pf_data;
  pws_pkg::raster_t     raster_q;

  pws_raster #(
    .H_ACTIVE (H_ACTIVE), .H_FRONT (H_FRONT), .H_SYNC (H_SYNC), .H_BACK (H_BACK),
    .V_ACTIVE (V_ACTIVE), .V_FRONT (V_FRONT), .V_SYNC (V_SYNC), .V_BACK (V_BACK),
    .WORD_BITS(WORD_BITS)
  ) u_raster (
    .clk          (clk),
    .rst          (rst),
    .in_active    (in_active),
    .word_slot    (word_slot),
    .frame_hit    (frame_hit),
    .raster_q     (raster_q),
    .frame_start_q(frame_start)
  );

  pws_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk     (clk),
    .rst     (rst),
    .async_in(word_ack),
    .level   (ack_level),
    .rise    (ack_rise)
  );

  pws_fetch #(
    .WORD_BITS      (WORD_BITS),
    .WORDS_PER_FRAME(WORDS_PER_FRAME)
  ) u_fetch (
    .clk        (clk),
    .rst        (rst),
    .frame_start(frame_start),
    .ack_level  (ack_level),
    .ack_rise   (ack_rise),
    .take       (word_slot),
    .word_in    (word_data),
    .req        (word_req),
    .pf_valid   (pf_valid),
    .pf_data    (pf_data)
  );

  pws_shifter #(.WORD_BITS(WORD_BITS)) u_shifter (
    .clk      (clk),
    .rst      (rst),
    .take     (word_slot),
    .in_active(in_active),
    .pf_valid (pf_valid),
    .pf_data  (pf_data),
    .pix      (pix),
    .underrun (underrun)
  );

  // Buffer choice is frozen for the frame, updated together with the pulse.
  always_ff @(posedge clk) begin
    if (rst)            scan_buf <= 1'b0;
    else if (frame_hit) scan_buf <= buf_sel;
  end

  assign de    = raster_q.de;
  assign hsync = raster_q.hs;
  assign vsync = raster_q.vs;

endmodule

// File: rtl/pws_checker.sv
module pws_checker (
  input logic clk,
  input logic rst,
  input logic word_req,
  input logic frame_start,
  input logic de,
  input logic hsync,
  input logic vsync,
  input logic pix,
  input logic underrun,
  input logic scan_buf,
  input logic ack_level,
  input logic ack_rise
);

  a_r7_dark_outside: assert property (@(posedge clk) disable iff (rst)
    !de |-> !pix);

  a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);

  a_r3_pulse_in_blank: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> !de);

  a_r5_start_when_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(word_req) |-> !ack_level);

  a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (word_req && !ack_rise) |=> word_req);

  a_r8_underrun_sticky: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun);

  a_r9_buf_frozen: assert property (@(posedge clk) disable iff (rst)
    !frame_start |-> $stable(scan_buf));

  a_r1_sync_apart: assert property (@(posedge clk) disable iff (rst)
    de |-> (!hsync && !vsync));

endmodule

bind pixword_scanout pws_checker u_pws_checker (
  .clk        (clk),
  .rst        (rst),
  .word_req   (word_req),
  .frame_start(frame_start),
  .de         (de),
  .hsync      (hsync),
  .vsync      (vsync),
  .pix        (pix),
  .underrun   (underrun),
  .scan_buf   (scan_buf),
  .ack_level  (ack_level),
  .ack_rise   (ack_rise)
);

// File: tb/pixword_scanout_tb_top.sv
`timescale 1ns/1ps
module pixword_scanout_tb_top;
  localparam int HA = 64, HF = 8, HS = 8, HB = 8;
  localparam int VA = 6,  VF = 1, VS = 2, VB = 1;
  localparam int WB = 16;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int WPF = (HA / WB) * VA;
  localparam int STALL_AT = 6;
  localparam int LAST_FS = 9;

  logic          clk = 1'b0, mclk = 1'b0, rst = 1'b1;
  logic          buf_sel = 1'b0;
  logic          word_ack;
  logic [WB-1:0] word_data;
  logic          word_req, scan_buf, frame_start, de, hsync, vsync, pix, underrun;

  int errors = 0, checks = 0;
  int unsigned salt;
  bit stall = 1'b0;
  bit mon_on = 1'b0;
  int fs_seen = 0;

  always #2.5 clk = ~clk;
  initial begin
    #0.7;
    forever #2 mclk = ~mclk;
  end

  pixword_scanout #(
    .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
    .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
    .WORD_BITS(WB), .SYNC_STAGES(2)
  ) dut_i (
    .clk(clk), .rst(rst), .buf_sel(buf_sel), .word_ack(word_ack),
    .word_data(word_data), .word_req(word_req), .scan_buf(scan_buf),
    .frame_start(frame_start), .de(de), .hsync(hsync), .vsync(vsync),
    .pix(pix), .underrun(underrun)
  );

  // Contents of the two modelled frame buffers.
  function automatic logic [15:0] mem_word(bit sel, int idx);
    logic [31:0] v;
    v = 32'(idx) * 32'd40503 + salt;
    v = v ^ (v >> 9);
    if (sel) v = v ^ 32'h0000_5AC3;
    return v[15:0];
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Memory-side responder on its own clock.
  logic rq1 = 1'b0, rq2 = 1'b0, rq3 = 1'b0, ack_r = 1'b0;
  logic [15:0] mdata = '0;
  int idx = 0, fs_mem = 0, delay_left = -1;

  assign word_ack  = ack_r & rq2;
  assign word_data = mdata;

  always @(posedge mclk) begin
    rq1 <= word_req;
    rq2 <= rq1;
    rq3 <= rq2;
    if (fs_mem != fs_seen) begin
      fs_mem = fs_seen;
      idx = 0;
    end
    if (!rq2) ack_r <= 1'b0;
    if (rq2 && !rq3 && !stall) begin
      mdata <= mem_word(scan_buf, idx);
      idx++;
      delay_left = int'($urandom_range(2, 0));
    end else if (delay_left > 0) begin
      delay_left--;
    end else if (delay_left == 0) begin
      ack_r <= 1'b1;
      delay_left = -1;
    end
  end

  // Pixel-domain monitor; also the only driver of buf_sel after reset.
  int  since_fs = 0, pc = 0, de_cnt = 0, hs_rises = 0, hs_run = 0, req_rises = 0;
  bit  have_frame = 1'b0, exp_sel = 1'b0, starving = 1'b0, first_de = 1'b0;
  bit  prev_req = 1'b0, prev_hs = 1'b0, prev_buf = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (frame_start) begin
        check(scan_buf == buf_sel, "R9 latch", int'(scan_buf), int'(buf_sel));
        check(!de, "R3 blank", int'(de), 0);
        if (have_frame) begin
          check(since_fs == HT * VT, "R3 period", since_fs, HT * VT);
          check(de_cnt == HA * VA, "R1 de count", de_cnt, HA * VA);
          check(hs_rises == VT, "R1 lines", hs_rises, VT);
          if (!starving) begin
            check(req_rises == WPF, "R4 requests", req_rises, WPF);
            check(underrun == 1'b0, "R10 no underrun", int'(underrun), 0);
          end else begin
            check(underrun == 1'b1, "R8 underrun set", int'(underrun), 1);
          end
        end else begin
          check(req_rises == 0, "R3 no early request", req_rises, 0);
        end
        if (fs_seen == STALL_AT) stall = 1'b1;
        starving   = stall;
        have_frame = 1'b1;
        since_fs   = 0;
        de_cnt     = 0;
        hs_rises   = 0;
        req_rises  = 0;
        pc         = 0;
        first_de   = 1'b1;
        exp_sel    = buf_sel;
        fs_seen++;
      end else begin
        check(scan_buf == prev_buf, "R9 hold", int'(scan_buf), int'(prev_buf));
      end

      if (de) begin
        logic [15:0] w;
        int          e;
        if (first_de) begin
          check(since_fs == HT, "R3 lead", since_fs, HT);
          first_de = 1'b0;
        end
        w = mem_word(exp_sel, pc / 16);
        e = starving ? 0 : int'(w[15 - (pc % 16)]);
        check(int'(pix) == e, starving ? "R8 dark" : "R6 pixel", int'(pix), e);
        pc++;
        de_cnt++;
      end else begin
        check(pix == 1'b0, "R7 blank pixel", int'(pix), 0);
      end

      if (hsync) hs_run++;
      if (hsync && !prev_hs) hs_rises++;
      if (!hsync && prev_hs) begin
        check(hs_run == HS, "R1 hsync width", hs_run, HS);
        hs_run = 0;
      end

      if (word_req && !prev_req) begin
        req_rises++;
        check(word_ack == 1'b0, "R5 raise idle", int'(word_ack), 0);
      end
      if (!word_req && prev_req)
        check(word_ack == 1'b1, "R5 drop on ack", int'(word_ack), 1);

      prev_req = word_req;
      prev_hs  = hsync;
      prev_buf = scan_buf;

      // Directed: flip the buffer choice right before a frame pulse;
      // otherwise flip it at random times.
      if (since_fs == HT * VT - 1 && (fs_seen % 2) == 0) buf_sel = ~buf_sel;
      else if ($urandom_range(60, 0) == 0) buf_sel = ~buf_sel;
      since_fs++;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    salt = $urandom(32'd7341);
    rst = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(word_req == 1'b0, "R2 req", int'(word_req), 0);
    check(frame_start == 1'b0, "R2 frame_start", int'(frame_start), 0);
    check(de == 1'b0, "R2 de", int'(de), 0);
    check(hsync == 1'b0 && vsync == 1'b0, "R2 sync", int'({hsync, vsync}), 0);
    check(pix == 1'b0, "R2 pix", int'(pix), 0);
    check(underrun == 1'b0, "R2 underrun", int'(underrun), 0);
    check(scan_buf == 1'b0, "R2 scan_buf", int'(scan_buf), 0);
    rst = 1'b0;
    mon_on = 1'b1;
    wait (fs_seen == LAST_FS);
    @(negedge clk);
    check(underrun == 1'b1, "R8 still set", int'(underrun), 1);
    finish_run();
  end

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R3 watchdog actual=%0d expected=%0d frames", fs_seen, LAST_FS);
    finish_run();
  end

endmodule